// File: doc/BRIEF.md
# Pin I/O Controller with Sticky Level-Match Interrupts

This block controls a bank of 32 general-purpose pins through a word-addressed register port with single-cycle reads and writes. For each pin, software decides whether the pin is owned by the controller or passed to an on-chip peripheral. It also sets the pin's direction and output value and picks the level that raises that pin's interrupt status. Input pins are synchronised before use. Software sees the synchronised value on data reads, and the peripheral side receives it as well.

The status bit of a pin is set whenever the pin's observed value equals its programmed trigger level. The bit stays set until software writes a 1 to it, and a clear loses to a match in the same cycle. A per-pin routing mask sends each status bit either to the non-maskable interrupt line or to the ordinary interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: During and directly after reset all six registers hold zero, every pin is a controller-owned input (pin_oe and pin_out are zero), and irq and nmi are low.
- R2: Word offsets are 0 owner select, 1 direction, 2 data, 3 trigger level, 4 status, 5 nmi routing. Offsets 0, 1, 3 and 5 read back the last value written. Reads of offsets 6 and 7 return zero, and writes to them change nothing.
- R3: A pin whose owner-select bit is 1 drives pin_out from alt_out and pin_oe from alt_oe.
- R4: A pin whose owner-select bit is 0 drives pin_oe from its direction bit (1 = output) and pin_out from the bit last written to offset 2.
- R5: A read of offset 2 returns, for each controller-owned output pin, its written value. For every other pin it returns pin_in delayed through two register stages, so a change shows up after the second rising edge.
- R6: A status bit is set on the edge after the cycle in which the pin's observed value (as read at offset 2) equals its trigger-level bit.
- R7: A status bit stays set after the match condition ends.
- R8: Writing 1 to a status bit at offset 4 clears it, and writing 0 leaves it unchanged. If the match holds in the same cycle, the bit stays set.
- R9: nmi is the OR of status bits whose routing bit is 1, and irq is the OR of status bits whose routing bit is 0.
- R10: alt_in carries pin_in through the same two-stage synchroniser for every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | 32 | Pad input values |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| alt_out | input | 32 | Peripheral output values |
| alt_oe | input | 32 | Peripheral output enables |
| alt_in | output | 32 | Synchronised pad values to peripherals |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The assertions check the status register's update rules on every cycle. A status bit only falls when a clear was requested without a match, a match always leaves its bit set on the next edge, and quiet status keeps both interrupt lines low. They also check reset clearing and zero reads of unmapped offsets. The pad multiplexing, the two-cycle synchroniser latency, clear-versus-match priority and the split between nmi and irq need the bench's scenarios. A reference model is compared against every output on every cycle, under directed and random traffic.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPIN = 32;
    localparam int DW   = 32;
    localparam int AW   = 3;

    typedef enum logic [AW-1:0] {
        OFS_OWNER = 3'd0,
        OFS_DIR   = 3'd1,
        OFS_DATA  = 3'd2,
        OFS_LEVEL = 3'd3,
        OFS_STAT  = 3'd4,
        OFS_ROUTE = 3'd5
    } reg_ofs_e;

    typedef struct packed {
        logic [NPIN-1:0] owner;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] level;
        logic [NPIN-1:0] route;
    } cfg_t;

    typedef struct packed {
        logic          sel;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    function automatic logic is_mapped(logic [AW-1:0] a);
        return a <= OFS_ROUTE;
    endfunction

    function automatic logic hits(bus_req_t r, reg_ofs_e o, logic write);
        return r.sel && (r.we == write) && (r.addr == o);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux
    import gpio_pkg::*;
(
    input  cfg_t            cfg,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe,
    input  logic [NPIN-1:0] sync_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_val
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic own_drive;
        assign own_drive  = !cfg.owner[i] && cfg.dir[i];
        assign pin_out[i] = cfg.owner[i] ? alt_out[i] : cfg.dout[i];
        assign pin_oe[i]  = cfg.owner[i] ? alt_oe[i]  : cfg.dir[i];
        assign pin_val[i] = own_drive ? cfg.dout[i] : sync_in[i];
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [NPIN-1:0] pin_val,
    input  logic [NPIN-1:0] stat,
    output cfg_t            cfg,
    output logic [NPIN-1:0] clr_mask,
    output logic [DW-1:0]   rdata
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (hits(req, OFS_OWNER, 1'b1)) cfg_q.owner <= req.wdata[NPIN-1:0];
            if (hits(req, OFS_DIR,   1'b1)) cfg_q.dir   <= req.wdata[NPIN-1:0];
            if (hits(req, OFS_DATA,  1'b1)) cfg_q.dout  <= req.wdata[NPIN-1:0];
            if (hits(req, OFS_LEVEL, 1'b1)) cfg_q.level <= req.wdata[NPIN-1:0];
            if (hits(req, OFS_ROUTE, 1'b1)) cfg_q.route <= req.wdata[NPIN-1:0];
        end
    end

    assign cfg      = cfg_q;
    assign clr_mask = hits(req, OFS_STAT, 1'b1) ? req.wdata[NPIN-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (req.sel && !req.we) begin
            case (req.addr)
                OFS_OWNER: rdata[NPIN-1:0] = cfg_q.owner;
                OFS_DIR:   rdata[NPIN-1:0] = cfg_q.dir;
                OFS_DATA:  rdata[NPIN-1:0] = pin_val;
                OFS_LEVEL: rdata[NPIN-1:0] = cfg_q.level;
                OFS_STAT:  rdata[NPIN-1:0] = stat;
                OFS_ROUTE: rdata[NPIN-1:0] = cfg_q.route;
                default:   rdata = '0;
            endcase
        end
    end

    // R2: unmapped offsets read as zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req.sel && !req.we && !is_mapped(req.addr)) |-> (rdata == '0));

    // R1: configuration is empty after a reset cycle
    assert_cfg_reset_R1: assert property (@(posedge clk)
        rst |=> (cfg_q == '0));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_val,
    input  logic [NPIN-1:0] level,
    input  logic [NPIN-1:0] route,
    input  logic [NPIN-1:0] clr_mask,
    output logic [NPIN-1:0] stat,
    output logic            irq,
    output logic            nmi
);
    logic [NPIN-1:0] stat_q;
    logic [NPIN-1:0] match;

    assign match = ~(pin_val ^ level);

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | match;
    end

    assign stat = stat_q;
    assign nmi  = |(stat_q & route);
    assign irq  = |(stat_q & ~route);

    // R1: status empty after a reset cycle
    assert_stat_reset_R1: assert property (@(posedge clk)
        rst |=> (stat_q == '0));

    // R6: every matching pin has its bit set on the next edge
    assert_match_sets_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(match) & ~stat_q) == '0));

    // R7: a set bit without a clear request stays set
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(stat_q) & ~$past(clr_mask) & ~stat_q) == '0));

    // R8: a bit only falls when cleared without a match
    assert_clear_cause_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(stat_q) & ~stat_q & ~($past(clr_mask) & ~$past(match))) == '0));

    // R9: no status, no interrupt
    assert_quiet_lines_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_q == '0) |-> (!irq && !nmi));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe,
    output logic [NPIN-1:0] alt_in,
    output logic            irq,
    output logic            nmi
);
    bus_req_t        req;
    cfg_t            cfg;
    logic [NPIN-1:0] sync_in;
    logic [NPIN-1:0] pin_val;
    logic [NPIN-1:0] stat;
    logic [NPIN-1:0] clr_mask;

    assign req = '{sel: bus_sel, we: bus_we, addr: bus_addr, wdata: bus_wdata};

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_in)
    );

    gpio_padmux u_mux (
        .cfg     (cfg),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .sync_in (sync_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_val (pin_val)
    );

    gpio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .pin_val  (pin_val),
        .stat     (stat),
        .cfg      (cfg),
        .clr_mask (clr_mask),
        .rdata    (bus_rdata)
    );

    gpio_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .pin_val  (pin_val),
        .level    (cfg.level),
        .route    (cfg.route),
        .clr_mask (clr_mask),
        .stat     (stat),
        .irq      (irq),
        .nmi      (nmi)
    );

    assign alt_in = sync_in;

    // R4: a controller-owned pin never drives when its direction is input
    assert_input_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ((~cfg.owner & ~cfg.dir & pin_oe) == '0));
endmodule

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/100ps
module sim_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0, alt_in;
    logic        irq, nmi;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_ctrl u0 (.*);

    // reference state
    logic [31:0] m_own, m_dir, m_dout, m_lvl, m_route, m_stat, m_s1, m_s2;

    function automatic logic [31:0] m_val();
        logic [31:0] drv;
        drv = ~m_own & m_dir;
        return (drv & m_dout) | (~drv & m_s2);
    endfunction

    function automatic logic [31:0] m_read();
        if (!bus_sel || bus_we) return 0;
        case (bus_addr)
            3'd0: return m_own;
            3'd1: return m_dir;
            3'd2: return m_val();
            3'd3: return m_lvl;
            3'd4: return m_stat;
            3'd5: return m_route;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] v, clr;
        if (rst) begin
            m_own = 0; m_dir = 0; m_dout = 0; m_lvl = 0;
            m_route = 0; m_stat = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            v   = m_val();
            clr = (bus_sel && bus_we && bus_addr == 3'd4) ? bus_wdata : 0;
            m_stat = (m_stat & ~clr) | ~(v ^ m_lvl);
            if (bus_sel && bus_we) begin
                case (bus_addr)
                    3'd0: m_own   = bus_wdata;
                    3'd1: m_dir   = bus_wdata;
                    3'd2: m_dout  = bus_wdata;
                    3'd3: m_lvl   = bus_wdata;
                    3'd5: m_route = bus_wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    task automatic check(string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] own_oe;
            own_oe = ~m_own;
            check("pin_out", pin_out, (m_own & alt_out) | (own_oe & m_dout));
            check("pin_oe",  pin_oe,  (m_own & alt_oe)  | (own_oe & m_dir));
            check("alt_in",  alt_in,  m_s2);
            check("rdata",   bus_rdata, m_read());
            check("irq",     {31'b0, irq}, {31'b0, |(m_stat & ~m_route)});
            check("nmi",     {31'b0, nmi}, {31'b0, |(m_stat & m_route)});
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk); #1;
            bus_sel = 0; bus_we = 0;
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        #0.5;
        tag = "R1";
        check("oe after reset", pin_oe, 0);
        check("out after reset", pin_out, 0);
        check("irq after reset", {31'b0, irq}, 0);
        rd(3'd0, d); check("owner reset", d, 0);
        rd(3'd5, d); check("route reset", d, 0);

        // quiet status: level ones against zero inputs
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        idle(1);
        rd(3'd4, d); check("status cleared", d, 0);

        tag = "R2";
        wr(3'd0, 32'hA5A5_5A5A); rd(3'd0, d); check("owner readback", d, 32'hA5A5_5A5A);
        wr(3'd1, 32'h0F0F_3C3C); rd(3'd1, d); check("dir readback", d, 32'h0F0F_3C3C);
        wr(3'd5, 32'h1234_0000); rd(3'd5, d); check("route readback", d, 32'h1234_0000);
        wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); check("offset 6", d, 0);
        rd(3'd7, d); check("offset 7", d, 0);
        rd(3'd0, d); check("owner after offset 6 write", d, 32'hA5A5_5A5A);
        wr(3'd5, 0);

        tag = "R4";
        wr(3'd0, 0);
        wr(3'd1, 32'hFFFF_0000);
        wr(3'd2, 32'hDEAD_BEEF);
        idle(1);
        check("pin_oe gpio", pin_oe, 32'hFFFF_0000);
        check("pin_out gpio", pin_out, 32'hDEAD_BEEF);
        tag = "R5";
        rd(3'd2, d); check("data mixed", d, 32'hDEAD_0000);

        tag = "R3";
        alt_out = 32'h0F0F_0F0F; alt_oe = 32'h00FF_00FF;
        wr(3'd0, 32'h0000_FFFF);
        idle(1);
        check("pin_oe alt", pin_oe, 32'hFFFF_00FF);
        check("pin_out alt", pin_out, 32'hDEAD_0F0F);

        tag = "R5";
        wr(3'd0, 0); wr(3'd1, 0);
        wr(3'd4, 32'hFFFF_FFFF);
        idle(3);
        @(negedge clk); #1;
        pin_in = 32'h1234_5678;
        bus_sel = 1; bus_we = 0; bus_addr = 3'd2;
        #0.5 check("data before sync", bus_rdata, 0);
        rd(3'd2, d); check("data after 1 edge", d, 0);
        rd(3'd2, d); check("data after 2 edges", d, 32'h1234_5678);
        tag = "R10";
        check("alt_in synced", alt_in, 32'h1234_5678);

        tag = "R6";
        pin_in = 0;
        idle(4);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); check("status empty", d, 0);
        pin_in = 32'h0000_0008;
        idle(4);
        rd(3'd4, d); check("match sets bit 3", d, 32'h0000_0008);
        tag = "R7";
        pin_in = 0;
        idle(4);
        rd(3'd4, d); check("bit 3 sticky", d, 32'h0000_0008);
        tag = "R8";
        wr(3'd4, 0);
        rd(3'd4, d); check("zero write keeps", d, 32'h0000_0008);
        wr(3'd4, 32'h0000_0008);
        rd(3'd4, d); check("one write clears", d, 0);
        pin_in = 32'h0000_0008;
        idle(4);
        wr(3'd4, 32'h0000_0008);
        rd(3'd4, d); check("match beats clear", d, 32'h0000_0008);
        tag = "R9";
        check("irq routed", {31'b0, irq}, 1);
        check("nmi unrouted", {31'b0, nmi}, 0);
        wr(3'd5, 32'h0000_0008);
        idle(1);
        check("irq after route", {31'b0, irq}, 0);
        check("nmi after route", {31'b0, nmi}, 1);

        tag = "R3 R4 R5 R6 R8 R9 random";
        for (int k = 0; k < 600; k++) begin
            @(negedge clk); #1;
            bus_sel = $urandom_range(0, 1);
            bus_we  = $urandom_range(0, 1);
            bus_addr = 3'($urandom_range(0, 7));
            bus_wdata = $urandom();
            if ((k % 7) == 0) pin_in = $urandom();
            if ((k % 11) == 0) begin alt_out = $urandom(); alt_oe = $urandom(); end
        end
        idle(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule